// File: doc/BRIEF.md
# RDS Bit-Clock Recovery and Symbol Decoder

This block takes the sign of an already demodulated RDS baseband, one sample per system clock cycle, and turns it into a recovered bit clock, a decoded data line and a per-bit quality flag. A phase counter spans one bit period of `BIT_LEN` system cycles (3648 by default, so a 4.332 MHz system clock gives a 1187.5 Hz bit clock). The counter is pulled into step with the mid-bit transition that every bi-phase symbol carries. It takes at most one count of correction in each bit, and it applies that correction by ending the current bit one cycle early or one cycle late.

Inside each bit period the input sign is integrated. Samples in the first half count positive and samples in the second half count negative. The sign of the total is the bi-phase symbol. The decoded data bit is the XOR of this symbol with the previous one. The magnitude of the total is compared against a threshold input. Together with a warm-up count after reset and a history of recent phase corrections, that comparison decides whether the bit is flagged good. The data and quality outputs are registered and change once per bit, in the same cycle that the recovered clock falls.

Top module: `rds_bit_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rData`, `qual` and `rClk` are all 0.
- R2: `rClk` is low for the first `BIT_LEN/2` cycles of each bit period and high for the rest, including any extra held cycle. It falls only in the cycle after a bit ends.
- R3: The symbol is 1 when the first-half-positive, second-half-negative integral of the input over the bit is greater than zero. Otherwise it is 0, and a zero total also gives 0.
- R4: The data bit equals the current symbol XOR the previous symbol. The previous symbol is 0 after reset.
- R5: `rData` and `qual` take their new value in the first cycle of the following bit period and hold it for the whole of that period.
- R6: When the first input transition inside the window lands after the mid-bit count, the bit period is stretched to `BIT_LEN+1` cycles.
- R7: When that transition lands before the mid-bit count, the bit period is shortened to `BIT_LEN-1` cycles. A transition exactly at mid-bit leaves the period at `BIT_LEN`.
- R8: Input transitions at phase counts below `BIT_LEN/4` or at or above `3*BIT_LEN/4` do not change the bit timing.
- R9: `qual` stays low for the first 15 decoded bits after reset. The 16th bit may be flagged good.
- R10: A bit is flagged bad when the magnitude of its integral is below `qualThresh`. A magnitude equal to the threshold is good.
- R11: A bit is flagged bad when a timing correction was made in each of the last 8 bits, including this one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| symIn | input | 1 | Sign of the demodulated baseband, one sample per cycle |
| qualThresh | input | MAG_W | Minimum integral magnitude for a good bit |
| rClk | output | 1 | Recovered bit clock |
| rData | output | 1 | Differentially decoded data |
| qual | output | 1 | High when the current data bit is judged good |

## Verification
Every decoded result is due in the cycle after the last cycle of its bit. That last cycle falls at count `BIT_LEN-1`, or one cycle later or earlier when a correction stretches or shortens the bit. The bench always sends each bit with the length that the requirements predict, so its own bit boundaries stay on the design's boundaries. It samples data and quality for the previous bit eight cycles into the next one, well away from the update cycle. It samples `rClk` eight cycles into each half, and samples `rData` a second time in the second half to confirm that it held.

// File: rtl/rds_pkg.sv
package rds_pkg;
  // strobes from the phase control to the symbol datapath
  typedef struct packed {
    logic firstHalf;  // current sample belongs to the positive half
    logic bitEnd;     // last cycle of the current bit period
    logic corrMade;   // a timing correction was taken in this bit
  } rdsStrobe_t;
endpackage

// File: rtl/rds_phase_ctrl.sv
module rds_phase_ctrl
  import rds_pkg::*;
#(
  parameter int BIT_LEN = 3648
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       symIn,
  output rdsStrobe_t strb,
  output logic       rClk
);
  localparam int PH_W = $clog2(BIT_LEN);
  localparam int HALF = BIT_LEN / 2;
  localparam int QTR  = BIT_LEN / 4;

  logic [PH_W-1:0] ph;
  logic prevIn, seen, corrUp, corrDn, held;
  logic edgeHit, inWin, holdNow, endNow;

  assign edgeHit = symIn != prevIn;
  assign inWin   = (ph >= PH_W'(QTR)) && (ph < PH_W'(3 * QTR));
  assign holdNow = (ph == PH_W'(BIT_LEN - 1)) && corrDn && !held;
  assign endNow  = ((ph == PH_W'(BIT_LEN - 1)) && !holdNow) ||
                   ((ph == PH_W'(BIT_LEN - 2)) && corrUp);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      prevIn <= 1'b0;
      seen   <= 1'b0;
      corrUp <= 1'b0;
      corrDn <= 1'b0;
      held   <= 1'b0;
    end else begin
      prevIn <= symIn;
      if (endNow) begin
        ph     <= '0;
        seen   <= 1'b0;
        corrUp <= 1'b0;
        corrDn <= 1'b0;
        held   <= 1'b0;
      end else if (holdNow) begin
        held <= 1'b1;
      end else begin
        ph <= ph + PH_W'(1);
        if (edgeHit && inWin && !seen) begin
          seen <= 1'b1;
          if (ph < PH_W'(HALF)) corrUp <= 1'b1;
          else if (ph > PH_W'(HALF)) corrDn <= 1'b1;
        end
      end
    end
  end

  assign strb.firstHalf = ph < PH_W'(HALF);
  assign strb.bitEnd    = endNow;
  assign strb.corrMade  = corrUp | corrDn;
  assign rClk           = ph >= PH_W'(HALF);

  // a stretched bit holds for exactly one extra cycle
  assert_single_hold_R6: assert property (@(posedge clk) disable iff (rst)
    holdNow |=> !holdNow && endNow);
  // never both directions of correction in one bit
  assert_one_dir_R7: assert property (@(posedge clk) disable iff (rst)
    !(corrUp && corrDn));
  // early transitions outside the window leave the bit free of correction
  assert_no_early_corr_R8: assert property (@(posedge clk) disable iff (rst)
    (ph < PH_W'(QTR)) |-> !seen);
endmodule

// File: rtl/rds_sym_dpath.sv
module rds_sym_dpath
  import rds_pkg::*;
#(
  parameter int BIT_LEN   = 3648,
  parameter int HIST_LEN  = 8,
  parameter int WARM_BITS = 16,
  parameter int MAG_W     = $clog2(BIT_LEN) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symIn,
  input  rdsStrobe_t       strb,
  input  logic [MAG_W-1:0] qualThresh,
  output logic             rData,
  output logic             qual
);
  localparam int ACC_W = MAG_W + 1;
  localparam int CNT_W = $clog2(WARM_BITS + 1);

  logic [ACC_W-1:0]    acc, total, magFull;
  logic [HIST_LEN-1:0] hist, histNext;
  logic [CNT_W-1:0]    bitCnt;
  logic symNow, prevSym, warmDone, qualNext;

  always_comb begin
    if (symIn == strb.firstHalf) total = acc + ACC_W'(1);
    else                         total = acc - ACC_W'(1);
    magFull  = total[ACC_W-1] ? (~total + ACC_W'(1)) : total;
    symNow   = !total[ACC_W-1] && (total != '0);
    histNext = {hist[HIST_LEN-2:0], strb.corrMade};
    warmDone = bitCnt >= CNT_W'(WARM_BITS - 1);
    qualNext = warmDone && (magFull >= {1'b0, qualThresh}) && !(&histNext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      hist    <= '0;
      bitCnt  <= '0;
      prevSym <= 1'b0;
      rData   <= 1'b0;
      qual    <= 1'b0;
    end else if (strb.bitEnd) begin
      acc     <= '0;
      hist    <= histNext;
      prevSym <= symNow;
      rData   <= symNow ^ prevSym;
      qual    <= qualNext;
      if (bitCnt != CNT_W'(WARM_BITS)) bitCnt <= bitCnt + CNT_W'(1);
    end else begin
      acc <= total;
    end
  end

  assert_warmup_R9: assert property (@(posedge clk) disable iff (rst)
    (bitCnt < CNT_W'(WARM_BITS)) |-> !qual);
  assert_weak_bit_R10: assert property (@(posedge clk) disable iff (rst)
    (strb.bitEnd && (magFull < {1'b0, qualThresh})) |=> !qual);
  assert_corr_run_R11: assert property (@(posedge clk) disable iff (rst)
    (&hist) |-> !qual);
endmodule

// File: rtl/rds_bit_decoder.sv
module rds_bit_decoder
  import rds_pkg::*;
#(
  parameter int BIT_LEN   = 3648,
  parameter int HIST_LEN  = 8,
  parameter int WARM_BITS = 16,
  localparam int MAG_W    = $clog2(BIT_LEN) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symIn,
  input  logic [MAG_W-1:0] qualThresh,
  output logic             rClk,
  output logic             rData,
  output logic             qual
);
  rdsStrobe_t strb;

  rds_phase_ctrl #(.BIT_LEN(BIT_LEN)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .symIn(symIn),
    .strb (strb),
    .rClk (rClk)
  );

  rds_sym_dpath #(
    .BIT_LEN  (BIT_LEN),
    .HIST_LEN (HIST_LEN),
    .WARM_BITS(WARM_BITS),
    .MAG_W    (MAG_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .symIn     (symIn),
    .strb      (strb),
    .qualThresh(qualThresh),
    .rData     (rData),
    .qual      (qual)
  );

  assert_data_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(rData) |-> $past(strb.bitEnd));
  assert_qual_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(qual) |-> $past(strb.bitEnd));
  assert_clk_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rClk) |-> $past(strb.bitEnd));
endmodule

// File: tb/rds_bit_decoder_tb.sv
module rds_bit_decoder_tb;
  localparam int L     = 64;
  localparam int HALF  = L / 2;
  localparam int MAG_W = $clog2(L) + 1;
  localparam int NV    = 33;

  typedef struct packed {
    logic       lvl;    // first-half level
    logic [1:0] mode;   // 0 clean, 1 early, 2 late
    logic [3:0] flips;  // inverted samples in each half
    logic       q;      // expected quality for this bit
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1,2'd0,4'd0,1'b0}, '{1'b0,2'd0,4'd0,1'b0}, '{1'b0,2'd0,4'd0,1'b0},
    '{1'b1,2'd0,4'd0,1'b0}, '{1'b1,2'd0,4'd0,1'b0}, '{1'b1,2'd0,4'd0,1'b0},
    '{1'b0,2'd0,4'd0,1'b0}, '{1'b1,2'd0,4'd0,1'b0}, '{1'b0,2'd0,4'd0,1'b0},
    '{1'b0,2'd0,4'd0,1'b0}, '{1'b0,2'd0,4'd0,1'b0}, '{1'b1,2'd0,4'd0,1'b0},
    '{1'b1,2'd0,4'd0,1'b0}, '{1'b0,2'd0,4'd0,1'b0}, '{1'b1,2'd0,4'd0,1'b0},
    '{1'b1,2'd0,4'd0,1'b1}, '{1'b0,2'd0,4'd0,1'b1}, '{1'b1,2'd0,4'd6,1'b1},
    '{1'b1,2'd0,4'd7,1'b0}, '{1'b0,2'd0,4'd0,1'b1},
    '{1'b1,2'd2,4'd0,1'b1}, '{1'b0,2'd2,4'd0,1'b1}, '{1'b0,2'd2,4'd0,1'b1},
    '{1'b1,2'd2,4'd0,1'b1}, '{1'b1,2'd2,4'd0,1'b1}, '{1'b0,2'd2,4'd0,1'b1},
    '{1'b1,2'd2,4'd0,1'b1}, '{1'b0,2'd2,4'd0,1'b0},
    '{1'b1,2'd1,4'd0,1'b0}, '{1'b0,2'd0,4'd0,1'b1},
    '{1'b1,2'd1,4'd0,1'b1}, '{1'b1,2'd1,4'd0,1'b1}, '{1'b1,2'd0,4'd0,1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic symIn = 1'b0;
  logic [MAG_W-1:0] qualThresh = MAG_W'(40);
  logic rClk, rData, qual;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic pendData, pendQual, mPrev;
  string pendTag;

  always #4 clk = ~clk;

  rds_bit_decoder #(.BIT_LEN(L)) u_dut (
    .clk(clk), .rst(rst), .symIn(symIn), .qualThresh(qualThresh),
    .rClk(rClk), .rData(rData), .qual(qual)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    symIn = 1'b0;
    repeat (3) @(negedge clk);
    chk(rData, 1'b0, "R1 rData in reset");
    chk(qual, 1'b0, "R1 qual in reset");
    chk(rClk, 1'b0, "R1 rClk in reset");
    rst = 1'b0;
    pendData = 1'b0;
    pendQual = 1'b0;
    pendTag = "R1 first bit";
    mPrev = 1'b0;
  endtask

  // one bit; the bench stretches or shortens it as R6/R7 predict
  task automatic sendBit(input logic lvl, input logic [1:0] mode,
                         input int flips, input logic qExp, input string qTag);
    int lenA, lenT;
    logic v, dNext;
    lenA = (mode == 2'd1) ? HALF - 1 : (mode == 2'd2) ? HALF + 1 : HALF;
    lenT = lenA + HALF;
    dNext = lvl ^ mPrev;  // R3 symbol is lvl, R4 xor with previous
    mPrev = lvl;
    for (int i = 0; i < lenT; i++) begin
      v = (i < lenA) ? lvl : !lvl;
      if ((i >= 2 && i < 2 + flips) || (i >= HALF + 18 && i < HALF + 18 + flips))
        v = !v;  // R8: these edges lie outside the timing window
      symIn = v;
      if (i == 8) begin
        chk(rData, pendData, {pendTag, " R3/R4 data"});
        chk(qual, pendQual, {pendTag, " qual"});
        chk(rClk, 1'b0, "R2 rClk low half");
      end
      if (i == lenA + 8) begin
        chk(rClk, 1'b1, "R2 rClk high half");
        chk(rData, pendData, "R5 data held");
      end
      @(negedge clk);
    end
    pendData = dNext;
    pendQual = qExp;
    pendTag = qTag;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    for (int k = 0; k < NV; k++) begin
      string tg;
      if (k < 16) tg = "R9 warm-up";
      else if (VECS[k].flips != 0) tg = "R10/R8 threshold";
      else if (VECS[k].mode == 2'd2) tg = "R6/R11 late";
      else if (VECS[k].mode == 2'd1) tg = "R7/R11 early";
      else tg = "R10 clean";
      sendBit(VECS[k].lvl, VECS[k].mode, int'(VECS[k].flips), VECS[k].q, tg);
    end
    sendBit(1'b0, 2'd0, 0, 1'b1, "R4 flush");
    sendBit(1'b1, 2'd0, 0, 1'b1, "R4 flush");

    // directed: reset mid-stream, then warm-up again
    doReset();
    for (int k = 0; k < 18; k++) begin
      logic l;
      l = ((k % 3) == 1);
      sendBit(l, 2'd0, 0, (k >= 15), "R9 after reset");
    end
    // directed: raised threshold makes clean bits weak
    qualThresh = MAG_W'(L + 1);
    sendBit(1'b0, 2'd0, 0, 1'b0, "R10 high threshold");
    qualThresh = MAG_W'(L);
    sendBit(1'b1, 2'd0, 0, 1'b1, "R10 equal threshold");
    sendBit(1'b1, 2'd0, 0, 1'b1, "R4 final");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule